// File: doc/BRIEF.md
# ASID-Tagged Fully Associative Translation Buffer

This block is a small on-chip translation cache for a 32-bit virtual address space made of 4 KB pages. A requester presents a virtual address, the identifier of the current address space and a flag telling whether the access is a write. One cycle later the block answers with one of three outcomes:

- a successful translation, with the physical address;
- a write-protection fault, when a write hits a page that may not be written;
- a miss, which tells the external refill engine to fetch the mapping. The block never walks the page table itself.

Every entry is tagged with the address-space identifier. Mappings that belong to different processes can therefore sit side by side, and a context switch needs no flush.

A refill engine inserts translations through a fill port. The block places each new mapping in a free slot if one exists. Otherwise it replaces the least recently used entry, tracked by per-entry age counters. A global flush clears every entry. A flush qualified by identifier clears only the entries of one address space.

Each entry also keeps a used bit and a dirty bit. The response reports both bits as they stood before the access, so software can see the first reference to a page and the first write to it.

Top module: `xlate_tlb`

## Requirements
- R1: A lookup whose VPN (address bits 31..12) and ASID both match a valid entry, and which is a read or a write to a writable page, gives rsp_valid=1 and rsp_hit=1 on the clock edge after the request. rsp_paddr is the entry's PPN in bits 31..12 with the request's address bits 11..0 below it unchanged.
- R2: A hit requires an equal ASID. Two entries with the same VPN and different ASIDs coexist, and each ASID receives its own PPN.
- R3: A lookup with no matching valid entry gives rsp_miss=1, rsp_hit=0, rsp_fault=0 and rsp_paddr=0.
- R4: A write that matches an entry whose write-permission bit is clear gives rsp_fault=1, rsp_hit=0 and rsp_paddr=0. It leaves the dirty bit of that entry clear.
- R5: rsp_was_used and rsp_was_dirty report the matching entry's bits as they were before the access. Any matching lookup, faulting ones included, sets the used bit. Only a permitted write sets the dirty bit. A fill clears both bits, and a miss reports both as 0.
- R6: A fill for a VPN/ASID pair not yet held goes to the lowest-numbered invalid entry. If every entry is valid, it replaces the entry whose last fill or matching lookup lies furthest in the past.
- R7: A fill whose VPN and ASID match a valid entry overwrites that entry, so no duplicate is created.
- R8: Priority is global flush, then ASID flush, then fill, then lookup. A lookup in a cycle that also carries a fill or a flush gets no response (rsp_valid=0 on the next cycle). A fill in a flush cycle is dropped.
- R9: flush_all invalidates every entry in one cycle. flush_asid_valid invalidates only the entries whose ASID equals flush_asid.
- R10: After reset no entry is valid and rsp_valid is 0.
- R11: When rsp_valid is 0, rsp_hit, rsp_fault, rsp_miss, rsp_was_used, rsp_was_dirty and rsp_paddr are all 0. When rsp_valid is 1, exactly one of rsp_hit, rsp_fault and rsp_miss is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Address space of the requester |
| lk_write | input | 1 | Lookup is a write access |
| fill_valid | input | 1 | Insert a translation |
| fill_vpn | input | VA_W-OFS_W | Virtual page number to insert |
| fill_asid | input | ASID_W | Address space of the inserted translation |
| fill_ppn | input | PA_W-OFS_W | Physical page number to insert |
| fill_wr_ok | input | 1 | Inserted page may be written |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_valid | input | 1 | Invalidate the entries of one address space |
| flush_asid | input | ASID_W | Address space to invalidate |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Write to a write-protected page |
| rsp_miss | output | 1 | No translation held; refill needed |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_was_used | output | 1 | Used bit of the matching entry before the access |
| rsp_was_dirty | output | 1 | Dirty bit of the matching entry before the access |

## Verification
The properties assume that every control input is known once reset is released. They also assume that the lookup address and write flag seen at an edge belong to the request that the next response answers. The bench meets both assumptions: it drives all inputs on the falling edge and returns the controls to zero after each operation. It raises two controls together only in the cycles that test priority. VPNs and ASIDs are drawn from a small pool on a four-entry configuration, so that matches, ASID aliases, faults and evictions all occur often. A scoreboard in the bench tracks the expected contents and recency order.

// File: rtl/xc_pkg.sv
package xc_pkg;

    // Per-entry permission and history bits
    typedef struct packed {
        logic wr_ok;
        logic used;
        logic dirty;
    } xc_flags_t;

    // Operation selected for a cycle, highest priority first
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_FLUSH_ALL,
        ACT_FLUSH_ASID,
        ACT_FILL,
        ACT_LOOKUP
    } xc_act_e;

endpackage

// File: rtl/xc_match.sv
module xc_match #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]             vld_vec,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_vec,
    input  logic [ENTRIES-1:0][ASID_W-1:0] asid_vec,
    input  logic [VPN_W-1:0]               key_vpn,
    input  logic [ASID_W-1:0]              key_asid,
    output logic                           hit,
    output logic [IDX_W-1:0]               idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = vld_vec[g] && (vpn_vec[g] == key_vpn) && (asid_vec[g] == key_asid);
    end

    assign hit = |eq;

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]            vld_vec,
    input  logic [ENTRIES-1:0][IDX_W-1:0] age_vec,
    output logic [IDX_W-1:0]              vic_idx
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic free_seen;

    always_comb begin
        vic_idx   = '0;
        free_seen = 1'b0;
        // descending scan leaves the lowest free slot selected
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_vec[i]) begin
                vic_idx   = IDX_W'(i);
                free_seen = 1'b1;
            end
        end
        if (!free_seen) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (age_vec[i] == OLDEST) vic_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xc_age.sv
module xc_age #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0][IDX_W-1:0] age_q,
    input  logic                          touch,
    input  logic [IDX_W-1:0]              touch_idx,
    output logic [ENTRIES-1:0][IDX_W-1:0] age_d
);
    // Ages form a permutation of 0..ENTRIES-1; 0 is most recent.
    logic [IDX_W-1:0] pivot;
    assign pivot = age_q[touch_idx];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
        localparam logic [IDX_W-1:0] SELF = IDX_W'(g);
        always_comb begin
            age_d[g] = age_q[g];
            if (touch) begin
                if (touch_idx == SELF)      age_d[g] = '0;
                else if (age_q[g] < pivot)  age_d[g] = age_q[g] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import xc_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFS_W   = 12,
    parameter int ASID_W  = 8,
    localparam int VPN_W  = VA_W - OFS_W,
    localparam int PPN_W  = PA_W - OFS_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_wr_ok,
    input  logic              flush_all,
    input  logic              flush_asid_valid,
    input  logic [ASID_W-1:0] flush_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic              rsp_miss,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_was_used,
    output logic              rsp_was_dirty
);
    typedef struct packed {
        logic              vld;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        xc_flags_t         flags;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0]            ent;
        logic   [ENTRIES-1:0][IDX_W-1:0] age;
        logic                            r_vld;
        logic                            r_hit;
        logic                            r_fault;
        logic                            r_miss;
        logic                            r_used;
        logic                            r_dirty;
        logic   [PA_W-1:0]               r_pa;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0]             vld_vec;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_vec;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_vec;
    logic [ENTRIES-1:0][IDX_W-1:0]  age_nx;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            vld_vec[i]  = st_q.ent[i].vld;
            vpn_vec[i]  = st_q.ent[i].vpn;
            asid_vec[i] = st_q.ent[i].asid;
        end
    end

    xc_act_e act;
    always_comb begin
        if (flush_all)             act = ACT_FLUSH_ALL;
        else if (flush_asid_valid) act = ACT_FLUSH_ASID;
        else if (fill_valid)       act = ACT_FILL;
        else if (lk_valid)         act = ACT_LOOKUP;
        else                       act = ACT_IDLE;
    end

    logic             lk_hit, fl_hit;
    logic [IDX_W-1:0] lk_idx, fl_idx, vic_idx;

    xc_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
        .vld_vec (vld_vec), .vpn_vec (vpn_vec), .asid_vec(asid_vec),
        .key_vpn (lk_vaddr[VA_W-1:OFS_W]), .key_asid(lk_asid),
        .hit     (lk_hit), .idx(lk_idx)
    );

    xc_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
        .vld_vec (vld_vec), .vpn_vec (vpn_vec), .asid_vec(asid_vec),
        .key_vpn (fill_vpn), .key_asid(fill_asid),
        .hit     (fl_hit), .idx(fl_idx)
    );

    xc_victim #(.ENTRIES(ENTRIES)) u_victim (
        .vld_vec(vld_vec), .age_vec(st_q.age), .vic_idx(vic_idx)
    );

    logic             touch;
    logic [IDX_W-1:0] touch_idx;
    always_comb begin
        touch     = (act == ACT_FILL) || ((act == ACT_LOOKUP) && lk_hit);
        touch_idx = (act == ACT_FILL) ? (fl_hit ? fl_idx : vic_idx) : lk_idx;
    end

    xc_age #(.ENTRIES(ENTRIES)) u_age (
        .age_q(st_q.age), .touch(touch), .touch_idx(touch_idx), .age_d(age_nx)
    );

    always_comb begin
        entry_t e;
        st_d         = st_q;
        st_d.r_vld   = 1'b0;
        st_d.r_hit   = 1'b0;
        st_d.r_fault = 1'b0;
        st_d.r_miss  = 1'b0;
        st_d.r_used  = 1'b0;
        st_d.r_dirty = 1'b0;
        st_d.r_pa    = '0;
        st_d.age     = age_nx;
        e            = st_q.ent[touch_idx];
        case (act)
            ACT_FLUSH_ALL: begin
                for (int i = 0; i < ENTRIES; i++) st_d.ent[i].vld = 1'b0;
            end
            ACT_FLUSH_ASID: begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (st_q.ent[i].asid == flush_asid) st_d.ent[i].vld = 1'b0;
                end
            end
            ACT_FILL: begin
                e.vld         = 1'b1;
                e.asid        = fill_asid;
                e.vpn         = fill_vpn;
                e.ppn         = fill_ppn;
                e.flags.wr_ok = fill_wr_ok;
                e.flags.used  = 1'b0;
                e.flags.dirty = 1'b0;
                st_d.ent[touch_idx] = e;
            end
            ACT_LOOKUP: begin
                st_d.r_vld = 1'b1;
                if (lk_hit) begin
                    st_d.r_used  = e.flags.used;
                    st_d.r_dirty = e.flags.dirty;
                    e.flags.used = 1'b1;
                    if (lk_write && !e.flags.wr_ok) begin
                        st_d.r_fault = 1'b1;
                    end else begin
                        st_d.r_hit = 1'b1;
                        st_d.r_pa  = {e.ppn, lk_vaddr[OFS_W-1:0]};
                        if (lk_write) e.flags.dirty = 1'b1;
                    end
                    st_d.ent[touch_idx] = e;
                end else begin
                    st_d.r_miss = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < ENTRIES; i++) st_q.age[i] <= IDX_W'(i);
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid     = st_q.r_vld;
    assign rsp_hit       = st_q.r_hit;
    assign rsp_fault     = st_q.r_fault;
    assign rsp_miss      = st_q.r_miss;
    assign rsp_paddr     = st_q.r_pa;
    assign rsp_was_used  = st_q.r_used;
    assign rsp_was_dirty = st_q.r_dirty;
endmodule

// File: rtl/xlate_tlb_chk.sv
module xlate_tlb_chk #(
    parameter int ENTRIES = 32,
    parameter int PA_W    = 32,
    parameter int OFS_W   = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [OFS_W-1:0]   lk_ofs,
    input logic               lk_write,
    input logic               fill_valid,
    input logic               flush_all,
    input logic               flush_asid_valid,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_fault,
    input logic               rsp_miss,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic               rsp_was_used,
    input logic               rsp_was_dirty,
    input logic [ENTRIES-1:0] vld_vec
);
    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_fault, rsp_miss}));

    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_fault && !rsp_miss && !rsp_was_used
                        && !rsp_was_dirty && rsp_paddr == '0));

    p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_hit -> rsp_paddr[OFS_W-1:0] == $past(lk_ofs)));

    p_fault_only_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_write |=> !rsp_fault);

    p_fill_blocks_lookup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !rsp_valid);

    p_lookup_answered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !fill_valid && !flush_all && !flush_asid_valid) |=> rsp_valid);

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (vld_vec == '0));
endmodule

bind xlate_tlb xlate_tlb_chk #(
    .ENTRIES(ENTRIES), .PA_W(PA_W), .OFS_W(OFS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ofs(lk_vaddr[OFS_W-1:0]),
    .lk_write(lk_write), .fill_valid(fill_valid), .flush_all(flush_all),
    .flush_asid_valid(flush_asid_valid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr),
    .rsp_was_used(rsp_was_used), .rsp_was_dirty(rsp_was_dirty), .vld_vec(vld_vec)
);

// File: tb/tb_xlate_tlb.sv
module tb_xlate_tlb;
    localparam int E  = 4;
    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [AW-1:0] lk_asid = '0;
    logic        lk_write = 1'b0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [AW-1:0] fill_asid = '0;
    logic [19:0] fill_ppn = '0;
    logic        fill_wr_ok = 1'b0;
    logic        flush_all = 1'b0;
    logic        flush_asid_valid = 1'b0;
    logic [AW-1:0] flush_asid = '0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_was_used, rsp_was_dirty;
    logic [31:0] rsp_paddr;

    xlate_tlb #(.ENTRIES(E), .VA_W(32), .PA_W(32), .OFS_W(12), .ASID_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_write(lk_write), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_ppn(fill_ppn),
        .fill_wr_ok(fill_wr_ok), .flush_all(flush_all),
        .flush_asid_valid(flush_asid_valid), .flush_asid(flush_asid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr), .rsp_was_used(rsp_was_used),
        .rsp_was_dirty(rsp_was_dirty)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // scoreboard
    bit          m_vld[E];
    logic [19:0] m_vpn[E];
    logic [AW-1:0] m_asid[E];
    logic [19:0] m_ppn[E];
    bit          m_wr[E];
    bit          m_used[E];
    bit          m_dirty[E];
    int          m_stamp[E];
    int          tnow = 0;

    function automatic logic [37:0] rsp_vec();
        return {rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_was_used, rsp_was_dirty, rsp_paddr};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int m_find(input logic [19:0] vpn, input logic [AW-1:0] asid);
        for (int i = 0; i < E; i++)
            if (m_vld[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
        return -1;
    endfunction

    function automatic int m_slot(input logic [19:0] vpn, input logic [AW-1:0] asid);
        int k;
        k = m_find(vpn, asid);
        if (k >= 0) return k;
        for (int i = 0; i < E; i++) if (!m_vld[i]) return i;
        k = 0;
        for (int i = 1; i < E; i++) if (m_stamp[i] < m_stamp[k]) k = i;
        return k;
    endfunction

    task automatic m_fill(input logic [19:0] vpn, input logic [AW-1:0] asid,
                          input logic [19:0] ppn, input bit wr);
        int k;
        k = m_slot(vpn, asid);
        m_vld[k] = 1; m_vpn[k] = vpn; m_asid[k] = asid; m_ppn[k] = ppn;
        m_wr[k] = wr; m_used[k] = 0; m_dirty[k] = 0;
        tnow++; m_stamp[k] = tnow;
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [AW-1:0] asid,
                           input logic [19:0] ppn, input bit wr);
        @(negedge clk);
        fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_ppn = ppn; fill_wr_ok = wr;
        @(negedge clk);
        fill_valid = 0;
        m_fill(vpn, asid, ppn, wr);
        // R11: no response after a fill cycle
        check(rsp_vec() == '0, "R11 quiet after fill", 64'(rsp_vec()), 64'd0);
    endtask

    task automatic do_flush_asid(input logic [AW-1:0] asid);
        @(negedge clk);
        flush_asid_valid = 1; flush_asid = asid;
        @(negedge clk);
        flush_asid_valid = 0;
        for (int i = 0; i < E; i++) if (m_asid[i] == asid) m_vld[i] = 0;
    endtask

    task automatic do_flush_all();
        @(negedge clk);
        flush_all = 1;
        @(negedge clk);
        flush_all = 0;
        for (int i = 0; i < E; i++) m_vld[i] = 0;
    endtask

    task automatic do_lookup(input logic [19:0] vpn, input logic [AW-1:0] asid,
                             input logic [11:0] ofs, input bit wr, input string tag);
        int k;
        logic [37:0] exp;
        string t;
        k = m_find(vpn, asid);
        if (k < 0) begin
            exp = {1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 32'h0};
            t = "R3 miss";
        end else if (wr && !m_wr[k]) begin
            exp = {1'b1, 1'b0, 1'b1, 1'b0, m_used[k], m_dirty[k], 32'h0};
            t = "R4 fault";
        end else begin
            exp = {1'b1, 1'b1, 1'b0, 1'b0, m_used[k], m_dirty[k], m_ppn[k], ofs};
            t = "R1 hit";
        end
        @(negedge clk);
        lk_valid = 1; lk_vaddr = {vpn, ofs}; lk_asid = asid; lk_write = wr;
        @(negedge clk);
        lk_valid = 0; lk_write = 0;
        check(rsp_vec() == exp, {tag, " ", t, " R5"}, 64'(rsp_vec()), 64'(exp));
        if (k >= 0) begin
            m_used[k] = 1;
            if (wr && m_wr[k]) m_dirty[k] = 1;
            tnow++; m_stamp[k] = tnow;
        end
    endtask

    task automatic probe_all(input string tag);
        logic [19:0] v[E];
        logic [AW-1:0] a[E];
        bit pv[E];
        for (int i = 0; i < E; i++) begin pv[i] = m_vld[i]; v[i] = m_vpn[i]; a[i] = m_asid[i]; end
        for (int i = 0; i < E; i++) if (pv[i]) do_lookup(v[i], a[i], 12'h5A5, 0, tag);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        for (int i = 0; i < E; i++) begin m_vld[i] = 0; m_stamp[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: reset state
        check(rsp_vec() == '0, "R10 reset quiet", 64'(rsp_vec()), 64'd0);
        do_lookup(20'h00005, 4'd0, 12'h000, 0, "R10 empty");

        // R1 / R2: same VPN, two ASIDs
        do_fill(20'h00010, 4'd1, 20'hABCDE, 1);
        do_fill(20'h00010, 4'd2, 20'h12345, 0);
        do_lookup(20'h00010, 4'd1, 12'h000, 0, "R2 asid1");
        do_lookup(20'h00010, 4'd2, 12'hFFF, 0, "R2 asid2");
        do_lookup(20'h00010, 4'd3, 12'h123, 0, "R2 other asid");
        // R4 fault, R5 bits
        do_lookup(20'h00010, 4'd2, 12'h010, 1, "R4 ro write");
        do_lookup(20'h00010, 4'd2, 12'h010, 0, "R4 dirty stays clear");
        do_lookup(20'h00010, 4'd1, 12'h7FF, 1, "R5 rw write");
        do_lookup(20'h00010, 4'd1, 12'h800, 0, "R5 dirty seen");

        // R6: fill to capacity, then evict least recent
        do_fill(20'hFFFFF, 4'd1, 20'h00001, 1);
        do_fill(20'h00000, 4'd0, 20'hFFFFF, 1);
        do_lookup(20'h00010, 4'd2, 12'h001, 0, "R6 touch");
        do_fill(20'h00777, 4'd5, 20'h0AAAA, 1);
        probe_all("R6 after evict");
        do_lookup(20'h00010, 4'd1, 12'h002, 0, "R6 evicted lru");
        do_fill(20'h00888, 4'd5, 20'h0BBBB, 0);
        probe_all("R6 second evict");

        // R7: refill of a held pair overwrites in place
        do_fill(20'h00777, 4'd5, 20'h0CCCC, 0);
        probe_all("R7 refresh");
        do_lookup(20'h00777, 4'd5, 12'h333, 0, "R7 new ppn");

        // R8: lookup together with fill gets no response, fill applies
        @(negedge clk);
        lk_valid = 1; lk_vaddr = {20'h00777, 12'h0}; lk_asid = 4'd5;
        fill_valid = 1; fill_vpn = 20'h00999; fill_asid = 4'd6; fill_ppn = 20'h0DDDD; fill_wr_ok = 1;
        @(negedge clk);
        lk_valid = 0; fill_valid = 0;
        m_fill(20'h00999, 4'd6, 20'h0DDDD, 1);
        check(rsp_vec() == '0, "R8 lookup vs fill", 64'(rsp_vec()), 64'd0);
        probe_all("R8 fill kept");
        // R8: fill during flush is dropped
        @(negedge clk);
        flush_all = 1; fill_valid = 1; fill_vpn = 20'h00ABC; fill_asid = 4'd1;
        fill_ppn = 20'h0EEEE; fill_wr_ok = 1;
        @(negedge clk);
        flush_all = 0; fill_valid = 0;
        for (int i = 0; i < E; i++) m_vld[i] = 0;
        do_lookup(20'h00ABC, 4'd1, 12'h000, 0, "R8 fill dropped");
        do_lookup(20'h00999, 4'd6, 12'h000, 0, "R9 flush all");

        // R9: ASID-qualified flush
        do_fill(20'h00001, 4'd1, 20'h11111, 1);
        do_fill(20'h00002, 4'd2, 20'h22222, 1);
        do_fill(20'h00003, 4'd1, 20'h33333, 1);
        do_flush_asid(4'd1);
        do_lookup(20'h00001, 4'd1, 12'h000, 0, "R9 asid flushed");
        do_lookup(20'h00003, 4'd1, 12'h000, 0, "R9 asid flushed");
        do_lookup(20'h00002, 4'd2, 12'h000, 0, "R9 other kept");
        // R6: freed low slots are reused first
        do_fill(20'h00004, 4'd3, 20'h44444, 0);
        do_fill(20'h00005, 4'd3, 20'h55555, 1);
        do_fill(20'h00006, 4'd3, 20'h66666, 1);
        probe_all("R6 free slots first");
        do_flush_all();
        probe_all("R9 none left");
        do_lookup(20'h00002, 4'd2, 12'h000, 0, "R9 flush all");

        // sweep over a small VPN/ASID pool
        seed = 32'h1234_5678;
        for (int n = 0; n < 3000; n++) begin
            int r;
            seed = seed * 32'd1103515245 + 32'd12345;
            r = int'(seed[30:24]) % 100;
            if (r < 25)
                do_fill(20'(seed[13:11] % 6), AW'(seed[10:9] % 3), {8'h0, seed[23:12]}, seed[5]);
            else if (r < 27)
                do_flush_asid(AW'(seed[10:9] % 3));
            else if (r < 28)
                do_flush_all();
            else
                do_lookup(20'(seed[13:11] % 6), AW'(seed[10:9] % 3), seed[23:12], seed[4], "R6 sweep");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule